// File: doc/BRIEF.md
# Converter Bus Control Interface

This block sits between a processor bus and the digital engine of a 12-bit successive-approximation converter. It watches five control lines: chip enable, active-low chip select, read/convert, byte address and a wide/narrow data-mode select. From them it produces a one-cycle conversion-start pulse, together with a short-cycle (8-bit) flag, for the conversion engine. During reads it places the engine's result on a 12-bit data bus. That bus is modelled as a data vector plus a per-bit output-enable vector, where an enable of 0 stands for high impedance.

A conversion can be started by three edges: a rising chip enable, a falling chip select or a falling read/convert. In each case the other qualifying conditions must already hold. When the start is accepted, the byte-address line is taken as the short-cycle request. A read returns either the whole 12-bit word or one of two left-justified bytes. The same block also serves the stand-alone use case. In that case chip select and byte address are tied low, chip enable and data mode are tied high, and a low pulse on read/convert alone starts a full conversion.

All control lines pass through a two-flop synchronizer before any decision is made. A minimum low-pulse width is enforced as a clock-cycle count derived from the clock period.

Top module: `conv_bus_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, `start_o`, `short_o`, `bus_oe_o` and `bus_data_o` are all zero.
- R2: With chip enable low or chip select high, no start pulse is issued and `bus_oe_o` stays zero, whatever read/convert does.
- R3: With chip enabled, selected and read/convert low, a conversion start is triggered by a falling read/convert, a rising chip enable or a falling chip select. For a falling read/convert held low, `start_o` is high in exactly the fifth clock cycle after the raw line first changes (default parameters).
- R4: `short_o` takes the byte-address value seen at the triggering edge: 1 means an 8-bit conversion and 0 means 12-bit. It keeps that value until the next accepted start, regardless of later byte-address changes.
- R5: After a triggering edge, read/convert must stay low for MIN_LOW_CYC = ceil(50 ns / clock period) sampled cycles, which is 3 at 50 MHz. A pulse sampled low for 3 clocks starts a conversion; a pulse sampled low for 2 clocks does not.
- R6: While `busy_i` is high, start edges are ignored. An edge seen during busy does not start a conversion once busy falls.
- R7: A read with read/convert high, busy low and data mode 1 drives all 12 result bits (`bus_oe_o` = 12'hFFF). The outputs are valid in the third clock cycle after the control lines change.
- R8: A read with data mode 0 and byte address 0 drives result[11:4] on bus bits [11:4]. In this case `bus_oe_o` = 12'hFF0 and bus bits [3:0] are 0.
- R9: A read with data mode 0 and byte address 1 drives result[3:0] on bus bits [11:8] and zeros on bits [7:4]. In this case `bus_oe_o` = 12'hFF0.
- R10: `bus_oe_o` is zero whenever read/convert is low or busy is high; busy removes it one cycle later. Data bits are zero whenever the bus is not driven.
- R11: In stand-alone wiring, a low pulse on read/convert starts a 12-bit conversion. Once busy falls with read/convert high, the full word is driven.
- R12: Each accepted start yields exactly one `start_o` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_en_i | input | 1 | Chip enable, active high (asynchronous) |
| chip_sel_n_i | input | 1 | Chip select, active low (asynchronous) |
| rd_conv_i | input | 1 | 1 = read, 0 = convert (asynchronous) |
| byte_addr_i | input | 1 | Byte select on reads, short-cycle request at start |
| wide_mode_i | input | 1 | 1 = 12-bit word reads, 0 = byte reads |
| busy_i | input | 1 | Conversion in progress, from the engine |
| result_i | input | RES_W | Conversion result from the engine |
| start_o | output | 1 | One-cycle conversion start pulse |
| short_o | output | 1 | 1 = 8-bit short conversion requested |
| bus_data_o | output | RES_W | Data bus value |
| bus_oe_o | output | RES_W | Per-bit drive enable (0 = high impedance) |

## Verification
Each control-line change takes two cycles through the synchronizer and one more through the output register, so read results are checked in the third cycle after the stimulus, and not before. The start pulse follows the edge, plus two further counted low cycles, plus its register. With default parameters that puts it in the fifth cycle, and the bench samples each cycle of that window to prove the pulse is neither early, late nor doubled. Busy affects the bus enable after one register, and that one-cycle delay is checked directly. The tests that expect no start wait well past the longest window before the bench compares its running start count.

// File: rtl/conv_bus_pkg.sv
// Shared types and constants for the converter bus control block.
// Assumes one clock domain for the engine side; bus controls are asynchronous.
package conv_bus_pkg;

    // Synchronized view of the five bus control lines.
    typedef struct packed {
        logic ce;
        logic cs_n;
        logic rc;
        logic ba;
        logic wide;
    } bus_ctl_t;

    localparam int CTL_W = 5;

    // Idle values loaded into the synchronizer on reset: deselected, read side.
    localparam bus_ctl_t CTL_IDLE = '{ce: 1'b0, cs_n: 1'b1, rc: 1'b1, ba: 1'b0, wide: 1'b1};

endpackage

// File: rtl/cbc_sync.sv
// Two-flop synchronizer, one chain per bit.
// Assumes each input bit is independent; no bus coherency is implied.
module cbc_sync #(
    parameter int               W       = 5,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic stab_q;

        // Two-stage capture of one asynchronous bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                stab_q <= RST_VAL[i];
            end else begin
                meta_q <= d_i[i];
                stab_q <= meta_q;
            end
        end

        assign q_o[i] = stab_q;
    end

endmodule

// File: rtl/cbc_start_ctl.sv
// Start qualification: detects a qualifying edge on synchronized controls,
// enforces a minimum low width on the convert condition, and issues one
// registered start pulse with the short-cycle flag captured at the edge.
// Assumes inputs are already synchronized to clk.
module cbc_start_ctl #(
    parameter int MIN_LOW_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_i,
    input  logic cs_n_i,
    input  logic rc_i,
    input  logic ba_i,
    input  logic busy_i,
    output logic start_o,
    output logic short_o
);

    localparam int CNT_W = $clog2(MIN_LOW_CYC + 1);
    localparam int HOLD  = (MIN_LOW_CYC > 1) ? MIN_LOW_CYC - 1 : 0;

    logic             ce_d, cs_n_d, rc_d;
    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic             short_cap_q;
    logic             start_q;
    logic             short_q;
    logic             cond;
    logic             edge_seen;

    // Convert condition and any of the three triggering edges.
    always_comb begin
        cond      = ce_i & ~cs_n_i & ~rc_i;
        edge_seen = (ce_i & ~ce_d) | (~cs_n_i & cs_n_d) | (~rc_i & rc_d);
    end

    // Arm on an edge, count low cycles, fire once, capture the short flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_d        <= 1'b0;
            cs_n_d      <= 1'b1;
            rc_d        <= 1'b1;
            armed_q     <= 1'b0;
            cnt_q       <= '0;
            short_cap_q <= 1'b0;
            start_q     <= 1'b0;
            short_q     <= 1'b0;
        end else begin
            ce_d    <= ce_i;
            cs_n_d  <= cs_n_i;
            rc_d    <= rc_i;
            start_q <= 1'b0;
            if (!armed_q) begin
                if (edge_seen && cond && !busy_i) begin
                    armed_q     <= 1'b1;
                    cnt_q       <= CNT_W'(1);
                    short_cap_q <= ba_i;
                end
            end else if (!cond || busy_i) begin
                armed_q <= 1'b0;
            end else if (cnt_q >= CNT_W'(HOLD)) begin
                armed_q <= 1'b0;
                start_q <= 1'b1;
                short_q <= short_cap_q;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign start_o = start_q;
    assign short_o = short_q;

endmodule

// File: rtl/cbc_read_path.sv
// Read gating and lane steering: drives the whole result or one left-justified
// byte on the upper lanes, with a per-bit enable; undriven bits read as zero.
// Assumes BYTE_W < RES_W <= 2*BYTE_W and synchronized control inputs.
module cbc_read_path #(
    parameter int RES_W  = 12,
    parameter int BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_i,
    input  logic             cs_n_i,
    input  logic             rc_i,
    input  logic             ba_i,
    input  logic             wide_i,
    input  logic             busy_i,
    input  logic [RES_W-1:0] result_i,
    output logic [RES_W-1:0] data_o,
    output logic [RES_W-1:0] oe_o
);

    localparam int TAIL_W = RES_W - BYTE_W;   // lanes below the byte lanes
    localparam int PAD_W  = BYTE_W - TAIL_W;  // trailing zeros in low byte

    logic              rd_ok;
    logic [BYTE_W-1:0] low_byte;
    logic [BYTE_W-1:0] byte_val;
    logic [RES_W-1:0]  nxt_data, nxt_oe;
    logic [RES_W-1:0]  data_q, oe_q;

    // Low byte: remaining LSBs left-justified, zero-padded if room is left.
    if (PAD_W > 0) begin : g_pad
        assign low_byte = {result_i[TAIL_W-1:0], {PAD_W{1'b0}}};
    end else begin : g_nopad
        assign low_byte = result_i[TAIL_W-1:0];
    end

    // Decide whether to drive and what goes on each lane.
    always_comb begin
        rd_ok    = ce_i & ~cs_n_i & rc_i & ~busy_i;
        byte_val = ba_i ? low_byte : result_i[RES_W-1 -: BYTE_W];
        nxt_data = '0;
        nxt_oe   = '0;
        if (rd_ok) begin
            if (wide_i) begin
                nxt_data = result_i;
                nxt_oe   = '1;
            end else begin
                nxt_data = {byte_val, {TAIL_W{1'b0}}};
                nxt_oe   = {{BYTE_W{1'b1}}, {TAIL_W{1'b0}}};
            end
        end
    end

    // Register the bus so lanes and enables change together without glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            oe_q   <= '0;
        end else begin
            data_q <= nxt_data;
            oe_q   <= nxt_oe;
        end
    end

    assign data_o = data_q;
    assign oe_o   = oe_q;

endmodule

// File: rtl/conv_bus_ctrl.sv
// Top of the converter bus control interface: synchronizes the control lines,
// qualifies conversion starts and steers the result onto the data bus.
// Assumes busy_i and result_i come from the engine in the clk domain.
module conv_bus_ctrl #(
    parameter int RES_W         = 12,
    parameter int BYTE_W        = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter int MIN_LOW_NS    = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_en_i,
    input  logic             chip_sel_n_i,
    input  logic             rd_conv_i,
    input  logic             byte_addr_i,
    input  logic             wide_mode_i,
    input  logic             busy_i,
    input  logic [RES_W-1:0] result_i,
    output logic             start_o,
    output logic             short_o,
    output logic [RES_W-1:0] bus_data_o,
    output logic [RES_W-1:0] bus_oe_o
);
    import conv_bus_pkg::*;

    localparam int MIN_LOW_CYC = (MIN_LOW_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

    bus_ctl_t raw_ctl;
    bus_ctl_t syn_ctl;

    // Pack the raw pins into one vector for the synchronizer.
    always_comb begin
        raw_ctl.ce   = chip_en_i;
        raw_ctl.cs_n = chip_sel_n_i;
        raw_ctl.rc   = rd_conv_i;
        raw_ctl.ba   = byte_addr_i;
        raw_ctl.wide = wide_mode_i;
    end

    cbc_sync #(
        .W       (CTL_W),
        .RST_VAL (CTL_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_ctl),
        .q_o   (syn_ctl)
    );

    cbc_start_ctl #(
        .MIN_LOW_CYC (MIN_LOW_CYC)
    ) u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_i    (syn_ctl.ce),
        .cs_n_i  (syn_ctl.cs_n),
        .rc_i    (syn_ctl.rc),
        .ba_i    (syn_ctl.ba),
        .busy_i  (busy_i),
        .start_o (start_o),
        .short_o (short_o)
    );

    cbc_read_path #(
        .RES_W  (RES_W),
        .BYTE_W (BYTE_W)
    ) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_i     (syn_ctl.ce),
        .cs_n_i   (syn_ctl.cs_n),
        .rc_i     (syn_ctl.rc),
        .ba_i     (syn_ctl.ba),
        .wide_i   (syn_ctl.wide),
        .busy_i   (busy_i),
        .result_i (result_i),
        .data_o   (bus_data_o),
        .oe_o     (bus_oe_o)
    );

endmodule

// File: rtl/cbc_checker.sv
// Protocol checker for conv_bus_ctrl, attached by bind below.
// Assumes synchronous active-low reset; all checks are off while in reset.
module cbc_checker #(
    parameter int RES_W  = 12,
    parameter int BYTE_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_i,
    input logic             start_o,
    input logic             short_o,
    input logic [RES_W-1:0] bus_data_o,
    input logic [RES_W-1:0] bus_oe_o
);

    localparam logic [RES_W-1:0] BYTE_MASK = {{BYTE_W{1'b1}}, {(RES_W-BYTE_W){1'b0}}};

    // R12: a start pulse lasts exactly one cycle.
    assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R4: the short flag only moves together with a new start pulse.
    assert_short_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (short_o != $past(short_o)) |-> start_o);

    // R6: no start is issued from a cycle in which the engine was busy.
    assert_no_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !$past(busy_i));

    // R10: the bus is never driven in the cycle after busy was high.
    assert_oe_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|bus_oe_o) |-> !$past(busy_i));

    // R10: undriven bus reads as all zero.
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o == '0) |-> (bus_data_o == '0));

    // R7: enables are all off, all on, or the upper byte lanes only.
    assert_oe_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o == '0) || (bus_oe_o == '1) || (bus_oe_o == BYTE_MASK));

endmodule

bind conv_bus_ctrl cbc_checker #(
    .RES_W  (RES_W),
    .BYTE_W (BYTE_W)
) u_cbc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_i     (busy_i),
    .start_o    (start_o),
    .short_o    (short_o),
    .bus_data_o (bus_data_o),
    .bus_oe_o   (bus_oe_o)
);

// File: tb/conv_bus_ctrl_test.sv
// Directed bench for conv_bus_ctrl: one task per scenario, each self-checking.
`timescale 1ns/1ps
module conv_bus_ctrl_test;

    localparam int RES_W   = 12;
    localparam int PERIOD  = 20;
    localparam int LOW_MIN = (50 + PERIOD - 1) / PERIOD;   // 3 samples

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ce = 1'b1, cs_n = 1'b0, rc = 1'b1, ba = 1'b0, wide = 1'b1;
    logic             force_busy = 1'b0;
    logic             busy;
    logic [RES_W-1:0] result = 12'hA5C;
    logic             start_o, short_o;
    logic [RES_W-1:0] bus_data_o, bus_oe_o;

    int n_checks = 0;
    int n_fail   = 0;
    int n_starts = 0;
    int eng_cnt  = 0;
    bit done     = 0;

    always #(PERIOD/2) clk = ~clk;

    conv_bus_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .chip_en_i    (ce),
        .chip_sel_n_i (cs_n),
        .rd_conv_i    (rc),
        .byte_addr_i  (ba),
        .wide_mode_i  (wide),
        .busy_i       (busy),
        .result_i     (result),
        .start_o      (start_o),
        .short_o      (short_o),
        .bus_data_o   (bus_data_o),
        .bus_oe_o     (bus_oe_o)
    );

    // Engine model: busy for a fixed time after each start pulse.
    always @(posedge clk) begin
        if (!rst_n) eng_cnt <= 0;
        else if (start_o) eng_cnt <= short_o ? 6 : 14;
        else if (eng_cnt != 0) eng_cnt <= eng_cnt - 1;
    end
    assign busy = (eng_cnt != 0) | force_busy;

    // Start pulse counter.
    always @(posedge clk) if (rst_n && start_o) n_starts <= n_starts + 1;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        ce = 1'b1; cs_n = 1'b0; rc = 1'b1; ba = 1'b0; wide = 1'b1; force_busy = 1'b0;
        tick(24);
    endtask

    task automatic pulse_rc(input int len);
        rc = 1'b0; tick(len); rc = 1'b1;
    endtask

    task automatic t_reset();
        tick(4);
        check(start_o == 0 && short_o == 0, "R1 start/short in reset", {start_o, short_o}, 0);
        check(bus_oe_o == 0 && bus_data_o == 0, "R1 bus in reset", bus_oe_o, 0);
        rst_n = 1'b1;
        tick(1);
        check(start_o == 0 && bus_oe_o == 0, "R1 after reset", bus_oe_o, 0);
        tick(8);
    endtask

    task automatic t_gate();
        int base = n_starts;
        ce = 1'b0; tick(2); pulse_rc(5); tick(6);
        check(bus_oe_o == 0, "R2 oe with chip disabled", bus_oe_o, 0);
        ce = 1'b1; cs_n = 1'b1; tick(2); pulse_rc(5); tick(6);
        check(bus_oe_o == 0, "R2 oe with chip deselected", bus_oe_o, 0);
        check(n_starts == base, "R2 no start when gated", n_starts - base, 0);
        go_idle();
    endtask

    task automatic t_rc_timing();
        int base = n_starts;
        bit early = 0;
        rc = 1'b0;
        for (int i = 1; i <= 4; i++) begin
            tick(1);
            if (start_o) early = 1;
        end
        check(!early, "R3 no start before cycle 5", early, 0);
        tick(1);
        check(start_o == 1, "R3 start in cycle 5", start_o, 1);
        check(short_o == 0, "R4 full conversion flag", short_o, 0);
        tick(1);
        check(start_o == 0, "R12 pulse one cycle", start_o, 0);
        go_idle();
        check(n_starts - base == 1, "R12 one pulse per start", n_starts - base, 1);
    endtask

    task automatic t_other_edges();
        int base = n_starts;
        ce = 1'b0; tick(2); rc = 1'b0; tick(6);
        check(n_starts == base, "R2 no start with ce low", n_starts - base, 0);
        ce = 1'b1; tick(10);
        check(n_starts - base == 1, "R3 start on rising ce", n_starts - base, 1);
        go_idle();
        base = n_starts;
        cs_n = 1'b1; tick(2); rc = 1'b0; tick(6); cs_n = 1'b0; tick(10);
        check(n_starts - base == 1, "R3 start on falling cs", n_starts - base, 1);
        go_idle();
    endtask

    task automatic t_short();
        bit moved = 0;
        ba = 1'b1; rc = 1'b0; tick(2); ba = 1'b0; tick(6);
        check(short_o == 1, "R4 short flag from edge", short_o, 1);
        rc = 1'b1;
        for (int i = 0; i < 6; i++) begin
            ba = ~ba; tick(1);
            if (short_o != 1) moved = 1;
        end
        check(!moved, "R4 flag held during conversion", moved, 0);
        go_idle();
        check(short_o == 1, "R4 flag held until next start", short_o, 1);
        pulse_rc(4); tick(8);
        check(short_o == 0, "R4 full flag on next start", short_o, 0);
        go_idle();
    endtask

    task automatic t_min_width();
        int base = n_starts;
        pulse_rc(LOW_MIN - 1); tick(10);
        check(n_starts == base, "R5 short pulse rejected", n_starts - base, 0);
        go_idle();
        base = n_starts;
        pulse_rc(LOW_MIN); tick(10);
        check(n_starts - base == 1, "R5 minimum pulse accepted", n_starts - base, 1);
        go_idle();
    endtask

    task automatic t_busy();
        int base = n_starts;
        force_busy = 1'b1; tick(2); pulse_rc(5); tick(10);
        check(n_starts == base, "R6 pulse ignored while busy", n_starts - base, 0);
        rc = 1'b0; tick(6); force_busy = 1'b0; tick(12);
        check(n_starts == base, "R6 edge during busy not replayed", n_starts - base, 0);
        go_idle();
    endtask

    task automatic t_reads();
        rc = 1'b0; tick(4); force_busy = 1'b1; tick(2);   // block any start
        force_busy = 1'b0; tick(4);
        rc = 1'b1; wide = 1'b1; result = 12'hA5C;
        tick(2);
        check(bus_oe_o == 0, "R7 not driven before cycle 3", bus_oe_o, 0);
        tick(1);
        check(bus_oe_o == 12'hFFF && bus_data_o == 12'hA5C, "R7 full word", bus_data_o, 12'hA5C);
        wide = 1'b0; ba = 1'b0; tick(3);
        check(bus_oe_o == 12'hFF0 && bus_data_o == 12'hA50, "R8 high byte", bus_data_o, 12'hA50);
        ba = 1'b1; tick(3);
        check(bus_oe_o == 12'hFF0 && bus_data_o == 12'hC00, "R9 low byte", bus_data_o, 12'hC00);
        result = 12'h3E7; tick(2);
        check(bus_data_o == 12'h700, "R9 low byte new result", bus_data_o, 12'h700);
        force_busy = 1'b1; tick(1);
        check(bus_oe_o == 0 && bus_data_o == 0, "R10 busy removes drive", bus_oe_o, 0);
        force_busy = 1'b0; tick(2);
        check(bus_oe_o == 12'hFF0, "R10 drive returns", bus_oe_o, 12'hFF0);
        ce = 1'b0; tick(3);
        check(bus_oe_o == 0 && bus_data_o == 0, "R10 released when disabled", bus_oe_o, 0);
        go_idle();
    endtask

    task automatic t_standalone();
        int base = n_starts;
        result = 12'h5A1;
        pulse_rc(4); tick(4);
        check(n_starts - base == 1 && short_o == 0, "R11 stand-alone 12-bit start", n_starts - base, 1);
        check(bus_oe_o == 0, "R11 not driven while busy", bus_oe_o, 0);
        tick(16);
        check(bus_oe_o == 12'hFFF && bus_data_o == 12'h5A1, "R11 word after busy", bus_data_o, 12'h5A1);
        go_idle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_gate();
        t_rc_timing();
        t_other_edges();
        t_short();
        t_min_width();
        t_busy();
        t_reads();
        t_standalone();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule